// File: doc/BRIEF.md
# Reconfigurable Single/Dual FIR Filter Core

This block is a streaming FIR datapath for signed 12-bit samples. One pool of sixteen coefficient slots and sixteen multipliers can be split at run time in one of two ways. It can act as one long filter, or as two independent filters, A and B, with eight slots each. A symmetric option adds mirrored samples together before each multiply, so the same multipliers cover twice the taps. An odd-length variant leaves the centre sample unpaired. Filter B can take its samples from the primary input or from an alternate input. Its 16-bit result leaves the block as a 12-bit low bus and a 4-bit high bus.

A new sample is taken on every clock. Coefficients are loaded through an address/data/write-enable port. A 4-bit mode input chooses the partition and the fold style. The mode decodes into two partition states, `PART_SINGLE` and `PART_DUAL`, and three fold states, `FOLD_NONE`, `FOLD_EVEN` and `FOLD_ODD`. Changing the mode input moves the block straight into the new state on the next cycle, with no flush. The delay lines keep their contents across the change. The sample that leaves the last delay stage is passed out on a cascade port.

Top module: `fir_dual_core`

## Requirements
- R1: While rst_n is low, and after it is released, the outputs, both delay lines and all sixteen coefficients are zero. Until new coefficients are written, any input therefore gives a zero output.
- R2: Samples and coefficients are signed two's complement. With mode bit 1 = 0 and bit 0 = 0, dout is bits [26:11] of the full-precision sum of c[k]*x[k] for k = 0..15. Here x[0] is the sample taken at the previous clock edge, and x[k] is the sample taken k edges before that. dout is registered, so a sample taken at edge e first affects dout after edge e+1.
- R3: With bit 1 = 0, bit 0 = 1 and bit 3 = 0, the filter has 32 taps over x[0..31], and c[k] weights both x[k] and x[31-k]. The 32-sample line is filter A's 16 stages followed by filter B's 16 stages.
- R4: With bit 0 = 1 and bit 3 = 1, the length is odd and the centre sample is unpaired. In single mode there are 31 taps: c[k] weights x[k] and x[30-k] for k < 15, and c[15] weights x[15] alone. In dual mode each filter has 15 taps: its slot k < 7 weights y[k] and y[14-k], and its slot 7 weights y[7] alone.
- R5: With bit 1 = 1, filter A uses coefficient slots 0..7 on its own 16-sample line fed by din, and drives dout with bits [26:11] of its sum. Filter A has 8 taps when bit 0 = 0 and 16 taps when bit 0 = 1 and bit 3 = 0, where slot k weights y[k] and y[15-k].
- R6: With bit 1 = 1, filter B uses coefficient slots 8..15 with the same fold rules as filter A. Its 16-sample line is fed by din when bit 2 = 0 and by alt_in when bit 2 = 1.
- R7: In dual mode, bout_lo carries bits [11:0] and bout_hi bits [15:12] of filter B's 16-bit result. In single mode both are zero.
- R8: A write with coef_we = 1 at a clock edge stores coef_data in slot coef_addr. The output computed at the following edge uses the new value. The output computed at that same write edge still uses the old value.
- R9: casc_out shows the last stage of filter B's line. In single mode this is the din sample taken 32 edges earlier. In dual mode it is filter B's input sample from 16 edges earlier.
- R10: Bit 3 has no effect when bit 0 = 0, and bit 2 has no effect when bit 1 = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 12 | Primary signed sample input |
| alt_in | input | 12 | Alternate signed sample input for filter B |
| mode_reg | input | 4 | bit0 symmetric, bit1 dual, bit2 filter B source (1 = alt_in), bit3 odd length |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 4 | Coefficient slot address 0..15 |
| coef_data | input | 12 | Signed coefficient value |
| dout | output | 16 | Single filter result, or filter A result in dual mode |
| bout_lo | output | 12 | Filter B result bits [11:0] |
| bout_hi | output | 4 | Filter B result bits [15:12] |
| casc_out | output | 12 | Sample leaving the last delay stage |

## Verification
The assertions check the clocked plumbing on every cycle. They check where line B takes its next sample in each partition and source setting, that a coefficient write lands in the addressed slot, that the filter B buses stay quiet in single mode, and that the outputs are cleared by reset. The arithmetic can only be shown by the bench scenarios. A reference model builds the full impulse response for every fold style and partition and compares dout and the filter B buses on every cycle. Directed cases add impulse responses, full-scale wrap-around and the exact cycle in which a coefficient write takes effect.

// File: rtl/fir_pkg.sv
package fir_pkg;

    // mode_reg bit positions
    localparam int MB_SYM  = 0;
    localparam int MB_DUAL = 1;
    localparam int MB_BSRC = 2;
    localparam int MB_ODD  = 3;

    typedef enum logic {
        PART_SINGLE,
        PART_DUAL
    } part_e;

    typedef enum logic [1:0] {
        FOLD_NONE,
        FOLD_EVEN,
        FOLD_ODD
    } fold_e;

    function automatic fold_e fold_of(input logic sym, input logic odd);
        if (!sym)
            return FOLD_NONE;
        return odd ? FOLD_ODD : FOLD_EVEN;
    endfunction

endpackage

// File: rtl/fir_tapline.sv
module fir_tapline #(
    parameter int W = 12,
    parameter int D = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [W-1:0]        shift_in,
    output logic [D-1:0][W-1:0] taps
);

    // taps[0] holds the newest sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            taps <= '0;
        else
            taps <= {taps[D-2:0], shift_in};
    end

endmodule

// File: rtl/fir_fold.sv
module fir_fold
    import fir_pkg::*;
#(
    parameter int W = 12,
    parameter int M = 8
) (
    input  logic [2*M-1:0][W-1:0] win,
    input  fold_e                 mode,
    output logic [M-1:0][W:0]     pa
);

    function automatic logic [W:0] ext(input logic [W-1:0] s);
        return {s[W-1], s};
    endfunction

    for (genvar k = 0; k < M; k++) begin : g_slot
        logic [W:0] v;
        always_comb begin
            unique case (mode)
                FOLD_NONE: v = ext(win[k]);
                FOLD_EVEN: v = ext(win[k]) + ext(win[2*M-1-k]);
                FOLD_ODD:  v = (k == M-1) ? ext(win[k])
                                          : ext(win[k]) + ext(win[2*M-2-k]);
                default:   v = ext(win[k]);
            endcase
        end
        assign pa[k] = v;
    end

endmodule

// File: rtl/fir_mac_bank.sv
module fir_mac_bank #(
    parameter int PW    = 13,
    parameter int CW    = 12,
    parameter int M     = 8,
    parameter int ACC_W = 30
) (
    input  logic [M-1:0][PW-1:0]    pa,
    input  logic [M-1:0][CW-1:0]    cf,
    output logic signed [ACC_W-1:0] sum
);

    localparam int PR_W = PW + CW;

    logic signed [PR_W-1:0] prod [M];

    for (genvar i = 0; i < M; i++) begin : g_mul
        assign prod[i] = $signed(pa[i]) * $signed(cf[i]);
    end

    always_comb begin
        sum = '0;
        for (int i = 0; i < M; i++)
            sum = sum + ACC_W'(prod[i]);
    end

endmodule

// File: rtl/fir_dual_core.sv
module fir_dual_core
    import fir_pkg::*;
#(
    parameter int SMP_W      = 12,
    parameter int CF_W       = 12,
    parameter int RES_W      = 16,
    parameter int BANK_SLOTS = 8,
    parameter int ACC_SHIFT  = 11,
    localparam int AW        = $clog2(2*BANK_SLOTS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SMP_W-1:0]       din,
    input  logic [SMP_W-1:0]       alt_in,
    input  logic [3:0]             mode_reg,
    input  logic                   coef_we,
    input  logic [AW-1:0]          coef_addr,
    input  logic [CF_W-1:0]        coef_data,
    output logic [RES_W-1:0]       dout,
    output logic [SMP_W-1:0]       bout_lo,
    output logic [RES_W-SMP_W-1:0] bout_hi,
    output logic [SMP_W-1:0]       casc_out
);

    localparam int NSLOT  = 2*BANK_SLOTS;
    localparam int LINE_D = 2*BANK_SLOTS;
    localparam int PA_W   = SMP_W + 1;
    localparam int ACC_W  = PA_W + CF_W + AW + 1;

    // coefficient slots
    logic [NSLOT-1:0][CF_W-1:0] coef_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            coef_q <= '0;
        else if (coef_we)
            coef_q[coef_addr] <= coef_data;
    end

    // mode decode
    part_e part;
    fold_e fold;
    assign part = mode_reg[MB_DUAL] ? PART_DUAL : PART_SINGLE;
    assign fold = fold_of(mode_reg[MB_SYM], mode_reg[MB_ODD]);

    // delay lines
    logic [LINE_D-1:0][SMP_W-1:0] la_q, lb_q;
    logic [SMP_W-1:0]             lb_in;

    always_comb begin
        unique case (part)
            PART_SINGLE: lb_in = la_q[LINE_D-1];
            PART_DUAL:   lb_in = mode_reg[MB_BSRC] ? alt_in : din;
            default:     lb_in = la_q[LINE_D-1];
        endcase
    end

    fir_tapline #(.W(SMP_W), .D(LINE_D)) u_line_a (
        .clk(clk), .rst_n(rst_n), .shift_in(din), .taps(la_q)
    );

    fir_tapline #(.W(SMP_W), .D(LINE_D)) u_line_b (
        .clk(clk), .rst_n(rst_n), .shift_in(lb_in), .taps(lb_q)
    );

    assign casc_out = lb_q[LINE_D-1];

    // symmetric pre-adders, one per partition view
    logic [2*LINE_D-1:0][SMP_W-1:0] win_s;
    logic [NSLOT-1:0][PA_W-1:0]      pa_s, pa_sel;
    logic [BANK_SLOTS-1:0][PA_W-1:0] pa_a, pa_b;

    assign win_s = {lb_q, la_q};

    fir_fold #(.W(SMP_W), .M(NSLOT)) u_fold_single (
        .win(win_s), .mode(fold), .pa(pa_s)
    );

    fir_fold #(.W(SMP_W), .M(BANK_SLOTS)) u_fold_a (
        .win(la_q), .mode(fold), .pa(pa_a)
    );

    fir_fold #(.W(SMP_W), .M(BANK_SLOTS)) u_fold_b (
        .win(lb_q), .mode(fold), .pa(pa_b)
    );

    for (genvar j = 0; j < NSLOT; j++) begin : g_sel
        if (j < BANK_SLOTS) begin : g_lo
            assign pa_sel[j] = (part == PART_SINGLE) ? pa_s[j] : pa_a[j];
        end else begin : g_hi
            assign pa_sel[j] = (part == PART_SINGLE) ? pa_s[j] : pa_b[j-BANK_SLOTS];
        end
    end

    // multiply-accumulate banks
    logic signed [ACC_W-1:0] sum_lo, sum_hi, sum_all;

    fir_mac_bank #(.PW(PA_W), .CW(CF_W), .M(BANK_SLOTS), .ACC_W(ACC_W)) u_mac_lo (
        .pa(pa_sel[BANK_SLOTS-1:0]), .cf(coef_q[BANK_SLOTS-1:0]), .sum(sum_lo)
    );

    fir_mac_bank #(.PW(PA_W), .CW(CF_W), .M(BANK_SLOTS), .ACC_W(ACC_W)) u_mac_hi (
        .pa(pa_sel[NSLOT-1:BANK_SLOTS]), .cf(coef_q[NSLOT-1:BANK_SLOTS]), .sum(sum_hi)
    );

    assign sum_all = sum_lo + sum_hi;

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout    <= '0;
            bout_lo <= '0;
            bout_hi <= '0;
        end else begin
            unique case (part)
                PART_SINGLE: begin
                    dout               <= sum_all[ACC_SHIFT +: RES_W];
                    {bout_hi, bout_lo} <= '0;
                end
                PART_DUAL: begin
                    dout               <= sum_lo[ACC_SHIFT +: RES_W];
                    {bout_hi, bout_lo} <= sum_hi[ACC_SHIFT +: RES_W];
                end
                default: begin
                    dout               <= '0;
                    {bout_hi, bout_lo} <= '0;
                end
            endcase
        end
    end

    // assertions
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (dout == '0 && bout_lo == '0 && bout_hi == '0)); // R1

    AST_LINEB_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_reg[MB_DUAL] |=> lb_q[0] == $past(la_q[LINE_D-1])); // R3

    AST_LINEB_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_reg[MB_DUAL] && mode_reg[MB_BSRC]) |=> lb_q[0] == $past(alt_in)); // R6

    AST_LINEB_PRI: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_reg[MB_DUAL] && !mode_reg[MB_BSRC]) |=> lb_q[0] == $past(din)); // R6

    AST_COEF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        coef_we |=> coef_q[$past(coef_addr)] == $past(coef_data)); // R8

    AST_BOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_reg[MB_DUAL] |=> (bout_lo == '0 && bout_hi == '0)); // R7

endmodule

// File: tb/fir_dual_core_bench.sv
module fir_dual_core_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] din = '0, alt_in = '0, coef_data = '0;
    logic [3:0]  mode_reg = '0, coef_addr = '0;
    logic        coef_we = 1'b0;
    logic [15:0] dout;
    logic [11:0] bout_lo, casc_out;
    logic [3:0]  bout_hi;

    fir_dual_core u_fir_dual_core (
        .clk(clk), .rst_n(rst_n), .din(din), .alt_in(alt_in),
        .mode_reg(mode_reg), .coef_we(coef_we), .coef_addr(coef_addr),
        .coef_data(coef_data), .dout(dout), .bout_lo(bout_lo),
        .bout_hi(bout_hi), .casc_out(casc_out)
    );

    always #10 clk = ~clk;   // 50 MHz

    int errors = 0;
    int checks = 0;

    // reference state
    int ma[16];
    int mb[16];
    int mc[16];
    logic        have_exp = 1'b0;
    logic [15:0] exp_d, exp_b;
    string       tag_d, tag_b;

    function automatic int sx12(input logic [11:0] v);
        return (v >= 12'd2048) ? int'(v) - 4096 : int'(v);
    endfunction

    // impulse response over 2n samples built from slots base..base+n-1
    function automatic longint fir_ref(input int base, input int n,
                                       input int xs[32], input logic [3:0] m);
        longint acc = 0;
        for (int k = 0; k < 2*n; k++) begin
            int h = 0;
            if (!m[0]) h = (k < n) ? mc[base+k] : 0;
            else if (!m[3]) h = (k < n) ? mc[base+k] : mc[base+2*n-1-k];
            else h = (k < n) ? mc[base+k] : ((k < 2*n-1) ? mc[base+2*n-2-k] : 0);
            acc += longint'(h) * longint'(xs[k]);
        end
        return acc;
    endfunction

    function automatic logic [15:0] cut(input longint acc);
        longint s = acc >>> 11;
        return s[15:0];
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 16; i++) begin
            ma[i] = 0; mb[i] = 0; mc[i] = 0;
        end
        have_exp = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; din = '0; alt_in = '0; coef_we = 1'b0; mode_reg = '0;
        repeat (3) @(negedge clk);
        chk("R1 dout", dout, 16'h0);
        chk("R1 bout", {bout_hi, bout_lo}, 16'h0);
        chk("R1 casc", {4'h0, casc_out}, 16'h0);
        rst_n = 1'b1;
        model_clear();
    endtask

    task automatic step(input logic [11:0] d, input logic [11:0] a, input logic [3:0] m,
                        input logic we, input logic [3:0] ad, input logic [11:0] cd,
                        input string tag);
        int xs[32];
        int bin;
        @(negedge clk);
        if (have_exp) begin
            chk(tag_d, dout, exp_d);
            chk(tag_b, {bout_hi, bout_lo}, exp_b);
        end
        chk("R9 casc", {4'h0, casc_out}, 16'(mb[15] & 32'hFFF));
        din = d; alt_in = a; mode_reg = m;
        coef_we = we; coef_addr = ad; coef_data = cd;
        if (m[1]) begin
            for (int k = 0; k < 16; k++) xs[k] = ma[k];
            exp_d = cut(fir_ref(0, 8, xs, m));
            for (int k = 0; k < 16; k++) xs[k] = mb[k];
            exp_b = cut(fir_ref(8, 8, xs, m));
            tag_d = "R5 filterA";
            tag_b = m[2] ? "R6 filterB alt R7" : "R6 filterB pri R7";
        end else begin
            for (int k = 0; k < 16; k++) begin
                xs[k] = ma[k]; xs[k+16] = mb[k];
            end
            exp_d = cut(fir_ref(0, 16, xs, m));
            exp_b = 16'h0;
            tag_d = !m[0] ? "R2 single" : (m[3] ? "R4 single odd" : "R3 single sym");
            tag_b = "R7 quiet";
        end
        if (m[0] && m[3]) tag_d = {tag_d, " R4"};
        if ((!m[0] && m[3]) || (!m[1] && m[2])) tag_d = {tag_d, " R10"};
        if (tag != "") begin
            tag_d = tag; tag_b = tag;
        end
        // advance model
        bin = m[1] ? (m[2] ? sx12(a) : sx12(d)) : ma[15];
        for (int k = 15; k > 0; k--) begin
            ma[k] = ma[k-1]; mb[k] = mb[k-1];
        end
        ma[0] = sx12(d); mb[0] = bin;
        if (we) mc[ad] = sx12(cd);
        have_exp = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_clear();
        do_reset();

        // R1: zero coefficients after reset give zero output
        for (int i = 0; i < 6; i++) step(12'd500, 12'd300, 4'b0000, 1'b0, 4'd0, 12'd0, "R1 zero coefs");

        // R8: write timing, steady input 100, slot 3 = 1024 (0.5)
        for (int i = 0; i < 18; i++) step(12'd100, 12'd0, 4'b0000, 1'b0, 4'd0, 12'd0, "R8 pre");
        step(12'd100, 12'd0, 4'b0000, 1'b1, 4'd3, 12'd1024, "R8 write edge");
        for (int i = 0; i < 3; i++) step(12'd100, 12'd0, 4'b0000, 1'b0, 4'd0, 12'd0, "R8 after");

        // R3: impulse response through 32-tap symmetric filter
        for (int s = 0; s < 16; s++) step(12'd0, 12'd0, 4'b0001, 1'b1, 4'(s), 12'(s*37+5), "");
        step(12'd1500, 12'd0, 4'b0001, 1'b0, 4'd0, 12'd0, "");
        for (int i = 0; i < 36; i++) step(12'd0, 12'd0, 4'b0001, 1'b0, 4'd0, 12'd0, "");

        // R4: odd impulse in single and dual
        step(12'hC00, 12'd0, 4'b1001, 1'b0, 4'd0, 12'd0, "");
        for (int i = 0; i < 34; i++) step(12'd0, 12'd0, 4'b1001, 1'b0, 4'd0, 12'd0, "");
        step(12'd900, 12'd700, 4'b1111, 1'b0, 4'd0, 12'd0, "");
        for (int i = 0; i < 18; i++) step(12'd0, 12'd0, 4'b1111, 1'b0, 4'd0, 12'd0, "");

        // full-scale wrap: all samples and coefficients at minimum
        for (int s = 0; s < 16; s++) step(12'h800, 12'h800, 4'b0001, 1'b1, 4'(s), 12'h800, "");
        for (int i = 0; i < 34; i++) step(12'h800, 12'h800, 4'b0001, 1'b0, 4'd0, 12'd0, "");
        for (int i = 0; i < 20; i++) step(12'h800, 12'h7FF, 4'b0111, 1'b0, 4'd0, 12'd0, "");

        // random phases over every mode value
        for (int blk = 0; blk < 32; blk++) begin
            logic [3:0] m = 4'(blk % 16);
            for (int i = 0; i < 60; i++) begin
                logic we = ($urandom() % 4) == 0;
                step(12'($urandom()), 12'($urandom()), m, we,
                     4'($urandom()), 12'($urandom()), "");
            end
        end

        // mid-run reset then R1 re-check
        do_reset();
        for (int i = 0; i < 5; i++) step(12'd777, 12'd555, 4'b0011, 1'b0, 4'd0, 12'd0, "R1 cleared");
        for (int i = 0; i < 40; i++)
            step(12'($urandom()), 12'($urandom()), 4'b0110, 1'b1, 4'($urandom()), 12'($urandom()), "");
        @(negedge clk);
        chk(tag_d, dout, exp_d);
        chk(tag_b, {bout_hi, bout_lo}, exp_b);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule